// File: doc/BRIEF.md
# Flash Command and Interrupt Register Unit

This block is the register front end of a NAND-style flash controller. Software writes a command code into a command register. The block classifies the code. Array operations (load, program and erase) go to an operation engine, which answers later with a done strobe and an error flag. Reset codes restart the register state at once. Lock and maintenance codes complete immediately. Unknown codes are flagged as command errors.

Completion is reported through an interrupt status register that holds per-class cause bits and a master bit. A controller status register holds latched error flags. While the master bit is pending, new commands are refused. Software clears interrupt bits by writing a mask that is ANDed into the register. Once the master bit is clear, every latched error flag is wiped as well.

A configuration register sets the polarity of the interrupt output and drives a ready output. A second configuration register is plain storage. The register bus is a 16-bit synchronous port with one cycle of read latency. The register map is: address 0 command, 1 configuration 1, 2 configuration 2, 3 status, 4 interrupt status.

Top module: `flash_cmd_regs`

## Requirements
- R1: After cold reset (`rst`): interrupt status reads 0x8080, status 0, configuration 1 reads 0x40C0, configuration 2 reads 0, command reads 0, `rdy` is 1 and `irq` is 1.
- R2: A command write is ignored while interrupt status bit 15 is set: the command register keeps its value and `op_start` stays low.
- R3: A write to interrupt status (address 4) ANDs the written value into it. When bit 15 of the result is 0, status bits 13..10 are cleared; otherwise they are kept.
- R4: `irq` equals interrupt status bit 15 XOR the inverse of configuration 1 bit 6.
- R5: Configuration 1 reads back as the stored value AND 0xFFE0. Configuration 2 reads back all 16 bits.
- R6: Writing configuration 1 sets `rdy` to bit 7 of the written value, from the next cycle on.
- R7: The engine codes are load 0x00/0x13, program 0x80/0x1A/0x1B and erase 0x94/0x30. An accepted engine code raises `op_start` for one cycle, starting at the accepting edge, with `op_code` equal to its low 8 bits. When `op_done` arrives, interrupt status gains bit 15 and a cause bit: bit 7 for load, bit 6 for program, bit 5 for erase.
- R8: If `op_err` is high with `op_done`, status gains bit 10 and a class bit: bit 13 for load, bit 12 for program, bit 11 for erase.
- R9: An unknown code sets status bit 10 and interrupt status bit 15 in the cycle after the write.
- R10: Codes 0xF0 and 0xF3, and a cycle with `warm_rst` high, perform a warm reset. Afterwards interrupt status is 0x8010, configuration 1 is 0x40C0, configuration 2, status and command are 0, and `rdy` is 1.
- R11: While an engine operation is outstanding, command writes are ignored. An `op_done` with nothing outstanding changes nothing.
- R12: Codes 0x23, 0x27, 0x2A, 0x2C, 0x71 and 0x65 set only interrupt status bit 15. Code 0xB0 sets no interrupt bit. Both kinds are stored in the command register.
- R13: `rdata` carries the addressed register in the cycle after `reg_rd`. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous cold reset, active high |
| warm_rst | input | 1 | Synchronous warm reset request |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after `reg_rd` |
| op_start | output | 1 | One-cycle start pulse to the operation engine |
| op_code | output | CODE_W | Command code given to the engine |
| op_done | input | 1 | Engine completion strobe |
| op_err | input | 1 | Engine error flag, valid with `op_done` |
| irq | output | 1 | Interrupt output, polarity set by configuration 1 bit 6 |
| rdy | output | 1 | Ready output |

## Verification
A wrong classification of a command code shows up on the very next read of interrupt status, or within one cycle on `op_start`. The bench walks all 256 low-byte codes for this reason. A stuck busy flag or a stuck master bit makes later commands vanish: the command register read-back stays unchanged and no start pulse appears. A failure to wipe the errors leaves stale status bits visible on the read that follows the interrupt clear. A wrong polarity term appears on `irq` at once, in the same cycle as the configuration or interrupt change.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int REG_W = 16;

    localparam logic [REG_W-1:0] INT_MASTER  = 16'h8000;
    localparam logic [REG_W-1:0] INT_RESET   = 16'h0010;
    localparam logic [REG_W-1:0] INT_ERASE   = 16'h0020;
    localparam logic [REG_W-1:0] INT_PROG    = 16'h0040;
    localparam logic [REG_W-1:0] INT_LOAD    = 16'h0080;

    localparam logic [REG_W-1:0] ERR_CMD     = 16'h0400;
    localparam logic [REG_W-1:0] ERR_ERASE   = 16'h0800;
    localparam logic [REG_W-1:0] ERR_PROG    = 16'h1000;
    localparam logic [REG_W-1:0] ERR_LOAD    = 16'h2000;
    localparam logic [REG_W-1:0] ERR_ALL     = 16'h3C00;

    localparam logic [REG_W-1:0] INT_COLD_VAL = INT_MASTER | INT_LOAD;
    localparam logic [REG_W-1:0] INT_WARM_VAL = INT_MASTER | INT_RESET;
    localparam logic [REG_W-1:0] CFG1_RST_VAL = 16'h40C0;
    localparam logic [REG_W-1:0] CFG1_RD_MASK = 16'hFFE0;

    localparam int CFG1_POL_BIT = 6;
    localparam int CFG1_RDY_BIT = 7;

    localparam int ADDR_CMD  = 0;
    localparam int ADDR_CFG1 = 1;
    localparam int ADDR_CFG2 = 2;
    localparam int ADDR_STAT = 3;
    localparam int ADDR_INT  = 4;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_LOAD,
        CLS_PROG,
        CLS_ERASE,
        CLS_RESET,
        CLS_FLAG,
        CLS_BAD
    } cmd_class_e;

    typedef struct packed {
        logic       valid;
        cmd_class_e cls;
        logic       err;
    } op_result_t;

    function automatic cmd_class_e classify(input logic [REG_W-1:0] code);
        case (code)
            16'h0000, 16'h0013:            return CLS_LOAD;
            16'h0080, 16'h001A, 16'h001B:  return CLS_PROG;
            16'h0094, 16'h0030:            return CLS_ERASE;
            16'h00F0, 16'h00F3:            return CLS_RESET;
            16'h0023, 16'h0027, 16'h002A,
            16'h002C, 16'h0071, 16'h0065:  return CLS_FLAG;
            16'h00B0:                      return CLS_NONE;
            default:                       return CLS_BAD;
        endcase
    endfunction

    function automatic logic is_engine(input cmd_class_e c);
        return (c == CLS_LOAD) || (c == CLS_PROG) || (c == CLS_ERASE);
    endfunction

    function automatic logic [REG_W-1:0] cause_of(input cmd_class_e c);
        case (c)
            CLS_LOAD:  return INT_LOAD;
            CLS_PROG:  return INT_PROG;
            CLS_ERASE: return INT_ERASE;
            default:   return '0;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] error_of(input cmd_class_e c);
        case (c)
            CLS_LOAD:  return ERR_LOAD;
            CLS_PROG:  return ERR_PROG;
            CLS_ERASE: return ERR_ERASE;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic             accept,
    input  logic [REG_W-1:0] code,
    output cmd_class_e       cls,
    output logic             engine_go,
    output logic             reset_go,
    output logic             flag_go,
    output logic             bad_go
);
    always_comb begin
        cls       = classify(code);
        engine_go = accept && is_engine(cls);
        reset_go  = accept && (cls == CLS_RESET);
        flag_go   = accept && (cls == CLS_FLAG);
        bad_go    = accept && (cls == CLS_BAD);
    end
endmodule

// File: rtl/flash_int_unit.sv
module flash_int_unit
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             warm_ev,
    input  logic             int_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             flag_go,
    input  logic             bad_go,
    input  op_result_t       done,
    output logic [REG_W-1:0] int_q,
    output logic [REG_W-1:0] stat_q
);
    logic [REG_W-1:0] int_n;
    logic [REG_W-1:0] stat_n;

    always_comb begin
        int_n  = int_q;
        stat_n = stat_q;
        if (int_wr) int_n = int_q & wdata;
        if (flag_go || bad_go) int_n = int_n | INT_MASTER;
        if (done.valid) int_n = int_n | INT_MASTER | cause_of(done.cls);
        if (!int_n[15]) stat_n = stat_n & ~ERR_ALL;
        if (bad_go) stat_n = stat_n | ERR_CMD;
        if (done.valid && done.err) stat_n = stat_n | ERR_CMD | error_of(done.cls);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q  <= INT_COLD_VAL;
            stat_q <= '0;
        end else if (warm_ev) begin
            int_q  <= INT_WARM_VAL;
            stat_q <= '0;
        end else begin
            int_q  <= int_n;
            stat_q <= stat_n;
        end
    end

    // R3: latched errors never outlive the master bit
    p_err_wiped_r3: assert property (@(posedge clk) disable iff (rst)
        !int_q[15] |-> (stat_q[13:10] == 4'b0000));

    // R9: a command error always comes with a pending master bit
    p_cmd_err_int_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[10]) |-> int_q[15]);
endmodule

// File: rtl/flash_cfg_unit.sv
module flash_cfg_unit
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             warm_ev,
    input  logic             cfg1_wr,
    input  logic             cfg2_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg1_q,
    output logic [REG_W-1:0] cfg2_q,
    output logic             rdy_q
);
    always_ff @(posedge clk) begin
        if (rst || warm_ev) begin
            cfg1_q <= CFG1_RST_VAL;
            cfg2_q <= '0;
            rdy_q  <= 1'b1;
        end else begin
            if (cfg1_wr) begin
                cfg1_q <= wdata;
                rdy_q  <= wdata[CFG1_RDY_BIT];
            end
            if (cfg2_wr) cfg2_q <= wdata;
        end
    end

    // R6: ready follows bit 7 of the last configuration-1 write
    p_rdy_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg1_wr && !warm_ev) |=> (rdy_q == $past(wdata[CFG1_RDY_BIT])));
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              op_start,
    output logic [CODE_W-1:0] op_code,
    input  logic              op_done,
    input  logic              op_err,
    output logic              irq,
    output logic              rdy
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ADDR_CMD);
    localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(ADDR_CFG1);
    localparam logic [ADDR_W-1:0] A_CFG2 = ADDR_W'(ADDR_CFG2);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(ADDR_INT);

    logic [REG_W-1:0] cmd_q, int_q, stat_q, cfg1_q, cfg2_q;
    logic             busy_q, start_q;
    logic [CODE_W-1:0] code_q;
    cmd_class_e       pend_q, cls;
    logic             accept, engine_go, reset_go, flag_go, bad_go, warm_ev;
    op_result_t       done;
    logic [REG_W-1:0] rd_mux, rdata_q;

    assign accept  = reg_wr && (reg_addr == A_CMD) && !int_q[15] && !busy_q && !warm_rst;
    assign warm_ev = warm_rst || reset_go;

    always_comb begin
        done.valid = op_done && busy_q;
        done.cls   = pend_q;
        done.err   = op_err;
    end

    flash_cmd_decode u_decode (
        .accept    (accept),
        .code      (reg_wdata),
        .cls       (cls),
        .engine_go (engine_go),
        .reset_go  (reset_go),
        .flag_go   (flag_go),
        .bad_go    (bad_go)
    );

    flash_int_unit u_int (
        .clk     (clk),
        .rst     (rst),
        .warm_ev (warm_ev),
        .int_wr  (reg_wr && (reg_addr == A_INT) && !warm_rst),
        .wdata   (reg_wdata),
        .flag_go (flag_go),
        .bad_go  (bad_go),
        .done    (done),
        .int_q   (int_q),
        .stat_q  (stat_q)
    );

    flash_cfg_unit u_cfg (
        .clk     (clk),
        .rst     (rst),
        .warm_ev (warm_ev),
        .cfg1_wr (reg_wr && (reg_addr == A_CFG1)),
        .cfg2_wr (reg_wr && (reg_addr == A_CFG2)),
        .wdata   (reg_wdata),
        .cfg1_q  (cfg1_q),
        .cfg2_q  (cfg2_q),
        .rdy_q   (rdy)
    );

    always_ff @(posedge clk) begin
        if (rst || warm_ev) begin
            cmd_q   <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            code_q  <= '0;
            pend_q  <= CLS_NONE;
        end else begin
            start_q <= engine_go;
            if (accept) cmd_q <= reg_wdata;
            if (engine_go) begin
                busy_q <= 1'b1;
                code_q <= reg_wdata[CODE_W-1:0];
                pend_q <= cls;
            end else if (done.valid) begin
                busy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_CMD:   rd_mux = cmd_q;
            A_CFG1:  rd_mux = cfg1_q & CFG1_RD_MASK;
            A_CFG2:  rd_mux = cfg2_q;
            A_STAT:  rd_mux = stat_q;
            A_INT:   rd_mux = int_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= reg_rd ? rd_mux : '0;
    end

    assign reg_rdata = rdata_q;
    assign op_start  = start_q;
    assign op_code   = code_q;
    assign irq       = int_q[15] ^ ~cfg1_q[CFG1_POL_BIT];

    // R2: a pending master bit blocks the command register
    p_refuse_pending_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == A_CMD) && int_q[15] && !warm_rst) |=> ($stable(cmd_q) && !start_q));

    // R7: the start strobe lasts a single cycle
    p_start_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    // R11: a start is always backed by an outstanding operation
    p_start_busy_r11: assert property (@(posedge clk) disable iff (rst)
        start_q |-> busy_q);
endmodule

// File: tb/test_flash_cmd_regs.sv
`timescale 1ns/1ps
module test_flash_cmd_regs;
    logic        clk = 0;
    logic        rst = 1, warm_rst = 0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        op_start, op_done = 0, op_err = 0, irq, rdy;
    logic [7:0]  op_code;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    flash_cmd_regs i_flash_cmd_regs (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .op_start(op_start), .op_code(op_code),
        .op_done(op_done), .op_err(op_err), .irq(irq), .rdy(rdy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic finish_op(input logic e);
        @(negedge clk);
        op_done = 1; op_err = e;
        @(negedge clk);
        op_done = 0; op_err = 0;
    endtask

    function automatic int cls_of(input logic [7:0] c);
        // 1 load, 2 prog, 3 erase, 4 reset, 5 flag, 0 none, 6 bad
        case (c)
            8'h00, 8'h13: return 1;
            8'h80, 8'h1A, 8'h1B: return 2;
            8'h94, 8'h30: return 3;
            8'hF0, 8'hF3: return 4;
            8'h23, 8'h27, 8'h2A, 8'h2C, 8'h71, 8'h65: return 5;
            8'hB0: return 0;
            default: return 6;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd(4, v); chk("R1 int", v, 16'h8080);
        rd(3, v); chk("R1 status", v, 16'h0000);
        rd(1, v); chk("R1 cfg1", v, 16'h40C0);
        rd(2, v); chk("R1 cfg2", v, 16'h0000);
        rd(0, v); chk("R1 cmd", v, 16'h0000);
        chk("R1 rdy", {15'b0, rdy}, 16'h1);
        chk("R1 irq", {15'b0, irq}, 16'h1);
        // R2 refusal while master pending
        wr(0, 16'h0000);
        chk("R2 no start", {15'b0, op_start}, 16'h0);
        wr(0, 16'h0023);
        rd(0, v); chk("R2 cmd kept", v, 16'h0000);

        // R7 R8 R9 R10 R12 sweep over all low-byte codes
        for (int c = 0; c < 256; c++) begin
            int k;
            logic e;
            logic [15:0] ei, es;
            k = cls_of(c[7:0]);
            e = c[0] ^ c[2];
            wr(4, 16'h0000);
            wr(0, {8'h00, c[7:0]});
            ei = 16'h0000; es = 16'h0000;
            if (k >= 1 && k <= 3) begin
                chk("R7 start", {15'b0, op_start}, 16'h1);
                chk("R7 code", {8'h00, op_code}, {8'h00, c[7:0]});
                finish_op(e);
                ei = 16'h8000 | (k == 1 ? 16'h0080 : k == 2 ? 16'h0040 : 16'h0020);
                if (e) es = 16'h0400 | (k == 1 ? 16'h2000 : k == 2 ? 16'h1000 : 16'h0800);
                rd(4, v); chk("R7 cause", v, ei);
                rd(3, v); chk("R8 errors", v, es);
            end else begin
                chk("R12 no start", {15'b0, op_start}, 16'h0);
                if (k == 4) ei = 16'h8010;
                if (k == 5) ei = 16'h8000;
                if (k == 6) begin ei = 16'h8000; es = 16'h0400; end
                rd(4, v); chk(k == 6 ? "R9 int" : k == 4 ? "R10 int" : "R12 int", v, ei);
                rd(3, v); chk(k == 6 ? "R9 status" : "R12 status", v, es);
            end
            rd(0, v); chk(k == 4 ? "R10 cmd" : "R12 cmd", v, k == 4 ? 16'h0000 : {8'h00, c[7:0]});
        end

        // R3 AND semantics and error wipe
        wr(4, 16'h0000);
        wr(0, 16'h0013);
        finish_op(1);
        wr(4, 16'h807F);
        rd(4, v); chk("R3 and keep", v, 16'h8000);
        rd(3, v); chk("R3 errors kept", v, 16'h2400);
        wr(4, 16'h7FFF);
        rd(4, v); chk("R3 and clear", v, 16'h0000);
        rd(3, v); chk("R3 errors wiped", v, 16'h0000);

        // R11 busy refusal and spurious done
        wr(0, 16'h0094);
        wr(0, 16'h0080);
        chk("R11 no restart", {15'b0, op_start}, 16'h0);
        rd(0, v); chk("R11 cmd kept", v, 16'h0094);
        rd(4, v); chk("R11 still clear", v, 16'h0000);
        finish_op(0);
        rd(4, v); chk("R11 erase done", v, 16'h8020);
        wr(4, 16'h0000);
        finish_op(1);
        rd(4, v); chk("R11 spurious int", v, 16'h0000);
        rd(3, v); chk("R11 spurious status", v, 16'h0000);

        // R4 irq polarity, all four combinations
        for (int b6 = 0; b6 < 2; b6++) begin
            for (int m = 0; m < 2; m++) begin
                wr(1, b6 ? 16'h00C0 : 16'h0080);
                wr(4, 16'h0000);
                if (m == 1) wr(0, 16'h00FF);
                chk("R4 irq", {15'b0, irq}, {15'b0, 1'(m) ^ ~1'(b6)});
            end
        end

        // R5 R6 config readback and ready
        wr(1, 16'hFFFF);
        rd(1, v); chk("R5 cfg1 mask", v, 16'hFFE0);
        chk("R6 rdy high", {15'b0, rdy}, 16'h1);
        wr(1, 16'h001F);
        rd(1, v); chk("R5 cfg1 low", v, 16'h0000);
        chk("R6 rdy low", {15'b0, rdy}, 16'h0);
        wr(2, 16'hA5C3);
        rd(2, v); chk("R5 cfg2", v, 16'hA5C3);

        // R10 warm reset pin
        @(negedge clk); warm_rst = 1;
        @(negedge clk); warm_rst = 0;
        rd(4, v); chk("R10 warm int", v, 16'h8010);
        rd(1, v); chk("R10 warm cfg1", v, 16'h40C0);
        rd(2, v); chk("R10 warm cfg2", v, 16'h0000);
        rd(3, v); chk("R10 warm status", v, 16'h0000);
        chk("R10 warm rdy", {15'b0, rdy}, 16'h1);

        // R13 unmapped addresses and latency
        for (int a = 5; a < 8; a++) begin
            rd(a[2:0], v); chk("R13 unmapped", v, 16'h0000);
        end
        @(negedge clk);
        chk("R13 idle rdata", reg_rdata, 16'h0000);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule